// File: doc/BRIEF.md
# Stack Push/Pop Transfer Sequencer

This block carries out a multi-word stack transfer for a processor core. A request supplies a 9-bit selection field, a direction bit and the current stack pointer. Bits [7:0] of the field pick the low registers 0 to 7. Bit 8 adds one more register: the link register (index 14) on a push, or the program counter (index 15) on a pop. The sequencer works out the block of stack words that the transfer covers. It then moves one 32-bit word per cycle between the register file and memory, and finishes by handing back the new stack pointer.

A push reads the register file and writes memory. A pop reads memory and writes the register file. On a pop that includes the program counter, the loaded word is checked: if its two low bits form the pattern 2'b10, the target cannot be reached and a flag is raised along with the completion pulse. A request that selects no register is refused with a one-cycle invalid pulse and does not touch memory.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `done`, `invalid`, `bad_target`, `mem_req`, `rf_re`, `rf_we` and `sp_we` are all 0.
- R2: For a push with N selected registers (N = popcount of `sel[7:0]` plus `sel[8]`), the first memory address is the aligned stack pointer minus 4*N. Each further transfer uses the address 4 above the previous one.
- R3: For a pop, the first memory address is the aligned stack pointer. Each further transfer uses the address 4 above the previous one.
- R4: Registers go in ascending index order, so the lowest selected index sits at the lowest address. The extra register selected by `sel[8]` comes last, at the highest address: index 14 on a push (`push`=1) and index 15 on a pop (`push`=0).
- R5: Exactly one word moves per cycle, in N consecutive cycles starting the cycle after the accepted `start`. `done` is high for exactly one cycle, the cycle after the last transfer.
- R6: In the `done` cycle, `sp_we` is 1. `sp_wdata` is the aligned stack pointer minus 4*N for a push, or plus 4*N for a pop (modulo 2^32).
- R7: On a push transfer, `mem_we`=1 and `rf_re`=1, `rf_ridx` names the register, and `mem_wdata` carries `rf_rdata`.
- R8: On a pop transfer, `mem_we`=0 and `rf_we`=1, `rf_widx` names the register, and `rf_wdata` carries `mem_rdata`.
- R9: `bad_target` is 1 in the `done` cycle only when the transfer was a pop with `sel[8]`=1 and the word loaded for index 15 had bits [1:0] equal to 2'b10. Otherwise it is 0.
- R10: A request with `sel` equal to zero gives `invalid`=1 for one cycle, the cycle after `start`. It makes no memory access, no register-file access, no `done` and no `sp_we`.
- R11: A `start` that arrives while a transfer is in progress is ignored. The ongoing sequence of addresses, indices and the final stack pointer stays unchanged.
- R12: Every issued memory address has bits [1:0] equal to 0. The low two bits of `sp_in` are treated as zero everywhere, including in the returned stack pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| push | input | 1 | 1 = push (store), 0 = pop (load) |
| sel | input | 9 | [7:0] low-register mask, [8] extra register |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Transfer or completion in progress |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | One-cycle pulse for an empty request |
| bad_target | output | 1 | Loaded program counter has low bits 2'b10 (valid with done) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory, same cycle |
| rf_re | output | 1 | Register-file read strobe |
| rf_ridx | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write strobe |
| rf_widx | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | 32 | Updated stack pointer |

## Verification
On every cycle, the assertions check that addresses are word-aligned and climb by one word between back-to-back accesses. They also check that each access strobes exactly one side of the register file, that `done` is a lone pulse directly after an access, and that `invalid` and `bad_target` never appear outside their proper context. Only the bench's scenarios can show the value-level results. These are the start address that depends on the population count, the exact index order with the extra register last, the returned stack pointer in each direction, the target check against chosen loaded patterns, and the fact that a `start` during a transfer leaves the sequence untouched.

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NLOW     = 8,
  parameter int IW       = 4,
  parameter int LINK_IDX = 14,
  parameter int PC_IDX   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          push,
  input  logic [NLOW:0] sel,
  input  logic [AW-1:0] sp_in,
  output logic          busy,
  output logic          done,
  output logic          invalid,
  output logic          bad_target,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_re,
  output logic [IW-1:0] rf_ridx,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [IW-1:0] rf_widx,
  output logic [DW-1:0] rf_wdata,
  output logic          sp_we,
  output logic [AW-1:0] sp_wdata
);
  localparam int CW = $clog2(NLOW + 2);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;

  st_t             st_q;
  logic [NLOW-1:0] pend_q;
  logic            ext_q, dir_q, flag_q, inv_q;
  logic [AW-1:0]   addr_q, sp_q;

  function automatic logic [CW-1:0] count_sel(input logic [NLOW:0] s);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i <= NLOW; i++) c = c + CW'(s[i]);
    return c;
  endfunction

  logic [CW-1:0]   n_sel;
  logic [AW-1:0]   base, span;
  logic [NLOW-1:0] pend_clr;
  logic            low_hit, last;
  logic [IW-1:0]   low_idx, cur_idx;
  logic            xfer;

  assign n_sel    = count_sel(sel);
  assign base     = {sp_in[AW-1:2], 2'b00};
  assign span     = AW'(n_sel) << 2;
  assign pend_clr = pend_q & (pend_q - 1'b1);

  always_comb begin
    low_hit = 1'b0;
    low_idx = '0;
    for (int i = NLOW - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        low_hit = 1'b1;
        low_idx = IW'(i);
      end
    end
  end

  assign cur_idx = low_hit ? low_idx : (dir_q ? IW'(LINK_IDX) : IW'(PC_IDX));
  assign last    = low_hit ? (pend_clr == '0 && !ext_q) : 1'b1;
  assign xfer    = (st_q == S_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      ext_q  <= 1'b0;
      dir_q  <= 1'b0;
      flag_q <= 1'b0;
      inv_q  <= 1'b0;
      addr_q <= '0;
      sp_q   <= '0;
    end else begin
      inv_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          if (n_sel == '0) begin
            inv_q <= 1'b1;
          end else begin
            st_q   <= S_XFER;
            pend_q <= sel[NLOW-1:0];
            ext_q  <= sel[NLOW];
            dir_q  <= push;
            flag_q <= 1'b0;
            addr_q <= push ? base - span : base;
            sp_q   <= push ? base - span : base + span;
          end
        end
        S_XFER: begin
          addr_q <= addr_q + AW'(4);
          if (low_hit) pend_q <= pend_clr;
          else begin
            ext_q <= 1'b0;
            if (!dir_q) flag_q <= (mem_rdata[1:0] == 2'b10);
          end
          if (last) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign done       = (st_q == S_DONE);
  assign invalid    = inv_q;
  assign bad_target = done & flag_q;
  assign mem_req    = xfer;
  assign mem_we     = xfer & dir_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = rf_rdata;
  assign rf_re      = xfer & dir_q;
  assign rf_ridx    = cur_idx;
  assign rf_we      = xfer & ~dir_q;
  assign rf_widx    = cur_idx;
  assign rf_wdata   = mem_rdata;
  assign sp_we      = done;
  assign sp_wdata   = sp_q;
endmodule

// File: rtl/stack_xfer_seq_chk.sv
module stack_xfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          invalid,
  input logic          bad_target,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          rf_re,
  input logic          rf_we,
  input logic          sp_we
);
  p_word_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + AW'(4));

  p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (rf_re != rf_we) && (mem_we == rf_re));

  p_done_after_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req) && !mem_req);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_sp_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !sp_we);

  p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> !busy && !mem_req && !sp_we);

  p_bad_ctx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_target |-> done && $past(rf_we));

  p_busy_needs_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind stack_xfer_seq stack_xfer_seq_chk u_chk (.*);

// File: tb/stack_xfer_seq_tb_top.sv
module stack_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        push = 1'b0;
  logic [8:0]  sel = '0;
  logic [31:0] sp_in = '0;
  logic [1:0]  pc_low = 2'b00;
  logic        busy, done, invalid, bad_target;
  logic        mem_req, mem_we, rf_re, rf_we, sp_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, sp_wdata;
  logic [3:0]  rf_ridx, rf_widx;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rf_val(input logic [3:0] idx);
    return {16'hC0DE, 12'h000, idx};
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[31:2] ^ 30'h15555555, pc_low};
  endfunction

  assign rf_rdata  = rf_val(rf_ridx);
  assign mem_rdata = mem_val(mem_addr);

  stack_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .push(push), .sel(sel), .sp_in(sp_in),
    .busy(busy), .done(done), .invalid(invalid), .bad_target(bad_target),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_re(rf_re), .rf_ridx(rf_ridx), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input logic is_push, input logic [8:0] s,
                        input logic [31:0] sp, input logic [1:0] pcl, input bit poke);
    int idxq[$];
    int n;
    logic [31:0] b, a0, exp_sp;
    for (int i = 0; i < 8; i++) if (s[i]) idxq.push_back(i);
    if (s[8]) idxq.push_back(is_push ? 14 : 15);
    n = idxq.size();
    b = {sp[31:2], 2'b00};
    a0 = is_push ? b - 32'(4*n) : b;
    exp_sp = is_push ? b - 32'(4*n) : b + 32'(4*n);

    @(negedge clk);
    start = 1'b1; push = is_push; sel = s; sp_in = sp; pc_low = pcl;
    @(negedge clk);
    if (poke) begin
      start = 1'b1; push = ~is_push; sel = 9'h1FF; sp_in = sp + 32'h100;
    end else start = 1'b0;

    if (n == 0) begin
      chk("R10 invalid pulse", invalid, 1);
      chk("R10 no mem access", mem_req, 0);
      chk("R10 idle", busy, 0);
      @(negedge clk);
      chk("R10 invalid single", invalid, 0);
      chk("R10 no done", done, 0);
      chk("R10 no sp write", sp_we, 0);
      chk("R10 no rf access", rf_re | rf_we, 0);
      return;
    end

    for (int k = 0; k < n; k++) begin
      chk("R5 mem_req per cycle", mem_req, 1);
      chk(is_push ? "R2 push address" : "R3 pop address", mem_addr, a0 + 32'(4*k));
      chk("R12 aligned", {30'h0, mem_addr[1:0]}, 0);
      chk("R5 no early done", done, 0);
      if (is_push) begin
        chk("R7 mem_we", mem_we, 1);
        chk("R7 rf_re", rf_re, 1);
        chk("R4 push order", rf_ridx, idxq[k]);
        chk("R7 wdata", mem_wdata, rf_val(4'(idxq[k])));
      end else begin
        chk("R8 mem_we low", mem_we, 0);
        chk("R8 rf_we", rf_we, 1);
        chk("R4 pop order", rf_widx, idxq[k]);
        chk("R8 rf_wdata", rf_wdata, mem_val(a0 + 32'(4*k)));
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk("R5 done pulse", done, 1);
    chk("R5 no access in done", mem_req, 0);
    chk("R6 sp_we", sp_we, 1);
    chk("R6 sp value", sp_wdata, exp_sp);
    chk("R9 bad_target", bad_target, (!is_push && s[8] && pcl == 2'b10));
    @(negedge clk);
    chk("R5 done single", done, 0);
    chk("R5 idle after", busy, 0);
    chk("R5 no access after", mem_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 strobes reset", {28'h0, mem_req, rf_re, rf_we, sp_we}, 0);
    chk("R1 flags reset", {30'h0, invalid, bad_target}, 0);
    rst_n = 1'b1;

    run_op(1'b1, 9'h0FF, 32'h0000_1000, 2'b00, 1'b0);
    run_op(1'b0, 9'h1A5, 32'h0000_0FE0, 2'b10, 1'b0);
    run_op(1'b0, 9'h103, 32'h0000_4000, 2'b00, 1'b0);
    run_op(1'b0, 9'h081, 32'h0000_4100, 2'b10, 1'b0);
    run_op(1'b1, 9'h100, 32'h0000_2003, 2'b00, 1'b0);
    run_op(1'b1, 9'h000, 32'h0000_3000, 2'b00, 1'b0);
    run_op(1'b0, 9'h000, 32'h0000_3000, 2'b10, 1'b0);
    run_op(1'b1, 9'h1FF, 32'h0000_0010, 2'b00, 1'b1);
    run_op(1'b0, 9'h0FF, 32'h0000_5002, 2'b00, 1'b1);
    run_op(1'b0, 9'h1FF, 32'h0000_8000, 2'b11, 1'b0);
    run_op(1'b0, 9'h140, 32'hFFFF_FFF8, 2'b10, 1'b0);
    run_op(1'b1, 9'h118, 32'h0000_0004, 2'b00, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule